// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

The block turns pointer events into a byte stream for a serial receive path. Each accepted event carries signed X and Y motion deltas and the state of three buttons. It becomes a fixed five-byte packet. A sequencer writes the packet into a small circular byte queue, one byte per clock. A consumer reads the queue through a pop strobe. The oldest byte is always visible on the data output, and a data-available flag shows whether the queue holds anything.

The packet starts with a header byte whose low three bits are an active-low button map. Two motion bytes follow, each clamped to a symmetric 8-bit range, and the vertical axis is sign-flipped. Two zero bytes end the packet. A new event waits behind a ready handshake while a packet is still being written. When the queue is full, incoming bytes are dropped without any indication. A synchronous clear empties the queue.

Top module: `mouse_pkt_enc`

## Requirements
- R1: An accepted event (`evt_valid_i` and `evt_ready_o` high at a clock edge) pushes exactly five bytes on the five following clock edges, one per edge. The order is header, X byte, Y byte, 0x00, 0x00.
- R2: The header byte is 0x87 with bit 2 cleared if the left button is pressed, bit 1 cleared if the middle button is pressed and bit 0 cleared if the right button is pressed.
- R3: The X byte is `dx_i` clamped to -127..+127, in 8-bit two's complement. For example +300 gives 0x7F and -300 gives 0x81.
- R4: The Y byte is the negation of `dy_i`, clamped to -127..+127, in 8-bit two's complement. For example +5 gives 0xFB and -512 gives 0x7F.
- R5: The queue is first-in first-out and holds `DEPTH` bytes, with `count_o` giving its fill level. A push is discarded when the count at the start of the cycle equals `DEPTH`, even if a pop happens in the same cycle.
- R6: `avail_o` is high exactly when the queue holds at least one byte. It goes high after any accepted push and stays high after a pop that leaves bytes behind.
- R7: `data_o` shows the oldest queued byte in the same cycle, and a pop removes that byte. When the queue is empty, `data_o` is 0x00 and a pop has no effect.
- R8: `evt_ready_o` is low from the edge that accepts an event until the fifth byte has been pushed. An event offered while ready is low is not taken and waits until ready returns.
- R9: `clear_i` empties the queue at the next edge. It takes precedence over a push and a pop in the same cycle. A packet already in progress continues with its remaining bytes.
- R10: After reset the queue is empty, `avail_o` is low, `data_o` is 0x00 and `evt_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous queue clear |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event can be accepted |
| dx_i | input | DELTA_W | Signed X motion |
| dy_i | input | DELTA_W | Signed Y motion |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| pop_i | input | 1 | Remove oldest byte |
| data_o | output | 8 | Oldest queued byte, 0x00 when empty |
| avail_o | output | 1 | Queue holds data |
| count_o | output | $clog2(DEPTH+1) | Queue fill level |

## Verification
The sequencer's push and the consumer's pop can land on the same edge. This matters most when the queue is full: the push must be dropped because the full check uses the count before the pop. Clear can also meet a push in the middle of a packet. The bench provokes these cases by filling the queue with back-to-back events and then popping every cycle while another packet streams in. It also raises clear partway through a packet and runs a random phase with concurrent valid, pop and rare clear. A behavioural queue model judges the ready, count, available and data outputs after every edge.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int PKT_LEN = 5;
  localparam logic [7:0] HDR_BASE = 8'h87;

  typedef logic [7:0] byte_t;

  // active-low button map in bits 2:0
  function automatic byte_t hdr_byte(input logic left, input logic mid, input logic right);
    return HDR_BASE & ~{5'b00000, left, mid, right};
  endfunction
endpackage

// File: rtl/mouse_pkt_former.sv
module mouse_pkt_former
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      evt_valid_i,
  output logic                      evt_ready_o,
  input  logic signed [DELTA_W-1:0] dx_i,
  input  logic signed [DELTA_W-1:0] dy_i,
  input  logic                      btn_left_i,
  input  logic                      btn_mid_i,
  input  logic                      btn_right_i,
  output logic                      push_o,
  output byte_t                     push_data_o
);
  localparam int EW = DELTA_W + 1;
  localparam int IW = $clog2(PKT_LEN);
  localparam logic signed [EW-1:0] LIM = EW'(127);

  function automatic byte_t clamp8(input logic signed [EW-1:0] v);
    if (v > LIM) return 8'h7f;
    if (v < -LIM) return 8'h81;
    return v[7:0];
  endfunction

  logic signed [EW-1:0] dx_ext, dy_neg;
  logic [PKT_LEN-1:0][7:0] pkt_d, pkt_q;
  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic          accept;

  assign dx_ext = EW'(dx_i);
  assign dy_neg = -EW'(dy_i);

  for (genvar b = 0; b < PKT_LEN; b++) begin : g_byte
    if (b == 0) begin : g_hdr
      assign pkt_d[b] = hdr_byte(btn_left_i, btn_mid_i, btn_right_i);
    end else if (b == 1) begin : g_x
      assign pkt_d[b] = clamp8(dx_ext);
    end else if (b == 2) begin : g_y
      assign pkt_d[b] = clamp8(dy_neg);
    end else begin : g_pad
      assign pkt_d[b] = '0;
    end
  end

  assign evt_ready_o = !busy_q;
  assign accept      = evt_valid_i && evt_ready_o;
  assign push_o      = busy_q;
  assign push_data_o = pkt_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      pkt_q  <= pkt_d;
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == IW'(PKT_LEN - 1)) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mouse_byte_fifo.sv
module mouse_byte_fifo
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       push_i,
  input  byte_t                      push_data_i,
  input  logic                       pop_i,
  output byte_t                      data_o,
  output logic                       avail_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic [DEPTH-1:0][7:0] ent_w;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // full test uses the count before this cycle's pop
  assign do_push = push_i && (count_q != CW'(DEPTH));
  assign do_pop  = pop_i && (count_q != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    byte_t ent_q;
    always_ff @(posedge clk_i) begin
      if (do_push && !clear_i && wr_q == PW'(g)) ent_q <= push_data_i;
    end
    assign ent_w[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign avail_o = (count_q != '0);
  assign data_o  = avail_o ? ent_w[rd_q] : 8'h00;
  assign count_o = count_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       evt_valid_i,
  output logic                       evt_ready_o,
  input  logic signed [DELTA_W-1:0]  dx_i,
  input  logic signed [DELTA_W-1:0]  dy_i,
  input  logic                       btn_left_i,
  input  logic                       btn_mid_i,
  input  logic                       btn_right_i,
  input  logic                       pop_i,
  output logic [7:0]                 data_o,
  output logic                       avail_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  logic  push_w;
  byte_t push_byte_w;

  mouse_pkt_former #(.DELTA_W(DELTA_W)) i_former (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .evt_ready_o (evt_ready_o),
    .dx_i        (dx_i),
    .dy_i        (dy_i),
    .btn_left_i  (btn_left_i),
    .btn_mid_i   (btn_mid_i),
    .btn_right_i (btn_right_i),
    .push_o      (push_w),
    .push_data_o (push_byte_w)
  );

  mouse_byte_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .push_i      (push_w),
    .push_data_i (push_byte_w),
    .pop_i       (pop_i),
    .data_o      (data_o),
    .avail_o     (avail_o),
    .count_o     (count_o)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clear_i,
  input logic                       evt_valid_i,
  input logic                       evt_ready_o,
  input logic                       pop_i,
  input logic                       push_i,
  input logic [7:0]                 push_data_i,
  input logic [7:0]                 data_o,
  input logic                       avail_o,
  input logic [$clog2(DEPTH+1)-1:0] count_o
);
  logic accept;
  assign accept = evt_valid_i && evt_ready_o;

  a_r1_five_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> push_i ##1 push_i ##1 push_i ##1 push_i ##1 push_i);

  a_r2_header_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> push_data_i[7] && (push_data_i[6:3] == 4'b0000));

  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !evt_ready_o);

  a_r5_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_o) == DEPTH) && !pop_i && !clear_i |=> int'(count_o) == DEPTH);

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (int'(count_o) <= int'($past(count_o)) + 1) &&
                 (int'(count_o) + 1 >= int'($past(count_o))));

  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  a_r7_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == '0 |-> data_o == 8'h00 && !avail_o);
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .evt_valid_i (evt_valid_i),
  .evt_ready_o (evt_ready_o),
  .pop_i       (pop_i),
  .push_i      (push_w),
  .push_data_i (push_byte_w),
  .data_o      (data_o),
  .avail_o     (avail_o),
  .count_o     (count_o)
);

// File: tb/test_mouse_pkt_enc.sv
`timescale 1ns/1ps
module test_mouse_pkt_enc;
  localparam int DEPTH = 16;
  localparam int DW    = 10;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, evt_valid_i = 1'b0, pop_i = 1'b0;
  logic btn_left_i = 1'b0, btn_mid_i = 1'b0, btn_right_i = 1'b0;
  logic signed [DW-1:0] dx_i = '0, dy_i = '0;
  logic evt_ready_o, avail_o;
  logic [7:0] data_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int failures = 0;
  int q[$];
  int pend[$];
  int ex_v, ey_v;
  logic el_v, em_v, er_v;

  always #2 clk_i = ~clk_i;

  mouse_pkt_enc #(.DEPTH(DEPTH), .DELTA_W(DW)) i_mouse_pkt_enc (
    .clk_i, .rst_ni, .clear_i, .evt_valid_i, .evt_ready_o,
    .dx_i, .dy_i, .btn_left_i, .btn_mid_i, .btn_right_i,
    .pop_i, .data_o, .avail_o, .count_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  // one clock: advance the model with the driven inputs, then compare
  task automatic step();
    int pre = q.size();
    bit push = (pend.size() > 0);
    bit rdy = (pend.size() == 0);
    int pb = push ? pend[0] : 0;
    if (clear_i) q.delete();
    else begin
      if (pop_i && pre > 0) void'(q.pop_front());
      if (push && pre < DEPTH) q.push_back(pb);
    end
    if (push) void'(pend.pop_front());
    if (evt_valid_i && rdy) begin
      int h = 'h87;
      if (btn_left_i)  h = h & ~4;
      if (btn_mid_i)   h = h & ~2;
      if (btn_right_i) h = h & ~1;
      pend.push_back(h);
      pend.push_back(clampv(int'(dx_i)) & 255);
      pend.push_back(clampv(-int'(dy_i)) & 255);
      pend.push_back(0);
      pend.push_back(0);
    end
    @(posedge clk_i);
    #1;
    chk("R8 ready", int'(evt_ready_o), int'(pend.size() == 0));
    chk("R5 count", int'(count_o), q.size());
    chk("R6 avail", int'(avail_o), int'(q.size() > 0));
    chk("R7 data", int'(data_o), (q.size() > 0) ? q[0] : 0);
  endtask

  task automatic set_evt(input int dx, input int dy, input logic l, input logic m, input logic r);
    dx_i = DW'(dx); dy_i = DW'(dy);
    btn_left_i = l; btn_mid_i = m; btn_right_i = r;
  endtask

  task automatic send(input int dx, input int dy, input logic l, input logic m, input logic r);
    bit took;
    set_evt(dx, dy, l, m, r);
    evt_valid_i = 1'b1;
    do begin
      took = evt_ready_o;
      step();
    end while (!took);
    evt_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (!evt_ready_o) step();
  endtask

  task automatic pop_expect(input int exp, input string tag);
    chk(tag, int'(data_o), exp);
    pop_i = 1'b1;
    step();
    pop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R10 reset state
    chk("R10 count", int'(count_o), 0);
    chk("R10 avail", int'(avail_o), 0);
    chk("R10 data", int'(data_o), 0);
    chk("R10 ready", int'(evt_ready_o), 1);

    // R1 R2 R3 R4 literal packets
    send(300, 5, 1'b1, 1'b0, 1'b0);
    chk("R8 busy after accept", int'(evt_ready_o), 0);
    wait_idle();
    pop_expect('h83, "R2 header left");
    pop_expect('h7f, "R3 x clamp high");
    pop_expect('hfb, "R4 y negated");
    pop_expect('h00, "R1 pad byte 3");
    pop_expect('h00, "R1 pad byte 4");

    send(-300, -512, 1'b0, 1'b0, 1'b0);
    wait_idle();
    pop_expect('h87, "R2 header none");
    pop_expect('h81, "R3 x clamp low");
    pop_expect('h7f, "R4 y from most negative");
    pop_expect('h00, "R1 pad");
    pop_expect('h00, "R1 pad");

    send(-127, 127, 1'b0, 1'b1, 1'b1);
    send(5, -3, 1'b1, 1'b1, 1'b1);
    wait_idle();
    pop_expect('h84, "R2 header mid right");
    pop_expect('h81, "R3 x at limit");
    pop_expect('h81, "R4 y at limit");
    pop_expect('h00, "R1 pad");
    pop_expect('h00, "R1 pad");
    pop_expect('h80, "R2 header all");
    pop_expect('h05, "R3 x small");
    pop_expect('h03, "R4 y small");
    pop_expect('h00, "R1 pad");
    pop_expect('h00, "R1 pad");

    // R7 empty pops
    pop_expect('h00, "R7 empty pop");
    pop_expect('h00, "R7 empty pop again");
    chk("R7 count stays zero", int'(count_o), 0);

    // R5 overflow by back-to-back events (R8 holds valid while busy)
    for (int i = 0; i < 4; i++) send(i * 10, -i, i[0], 1'b0, i[1]);
    wait_idle();
    chk("R5 full count", int'(count_o), DEPTH);
    // push meets pop while full
    set_evt(77, 77, 1'b0, 1'b1, 1'b0);
    evt_valid_i = 1'b1;
    step();
    evt_valid_i = 1'b0;
    pop_i = 1'b1;
    repeat (7) step();
    pop_i = 1'b0;
    while (count_o != 0) pop_expect((q.size() > 0) ? q[0] : 0, "R5 drain order");

    // R9 clear mid-packet
    send(12, 34, 1'b0, 1'b0, 1'b1);
    step();
    step();
    clear_i = 1'b1;
    pop_i = 1'b1;
    step();
    clear_i = 1'b0;
    pop_i = 1'b0;
    chk("R9 clear empties", int'(count_o), 0);
    wait_idle();
    chk("R9 remaining bytes kept", int'(count_o), 2);

    // random concurrent traffic
    for (int c = 0; c < 600; c++) begin
      evt_valid_i = ($urandom_range(0, 3) == 0);
      if (evt_ready_o)
        set_evt($urandom_range(0, 1023) - 512, $urandom_range(0, 1023) - 512,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      pop_i = ($urandom_range(0, 4) < 2);
      clear_i = ($urandom_range(0, 63) == 0);
      step();
    end
    evt_valid_i = 1'b0; pop_i = 1'b0; clear_i = 1'b0;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule